// File: doc/BRIEF.md
# RPN Stack Calculator

This block is an 8-bit reverse-Polish calculator whose working storage is a 32-entry last-in-first-out stack. A caller presents a one-cycle command strobe with a 3-bit operation code and, for pushes, an 8-bit operand. The stack can take a value, drop its top, add, subtract, negate, exchange its two top entries, or be emptied. The current top entry is always visible on the output, together with empty, full, stack-overflow and arithmetic-overflow flags.

Push, pop and clear finish at the clock edge that accepts them. Add, subtract, negate and swap run as a short fixed sequence through the single stack port. The operands are popped into two holding registers, the result is computed by a shared adder that subtracts by inverting the second operand and feeding in a carry, and the result is pushed back. While such a sequence runs, `busy_o` is high and any new command is dropped. A command that cannot run, because the stack holds too few entries, leaves the stack untouched and raises a one-cycle error pulse.

Top module: `rpn_stack_calc`

## Requirements
- R1: A push (op code 0) places `operand_i` on top at the accepting edge without raising `busy_o`. `empty_o` is high whenever the stack holds no entries, and `top_o` reads 0 while the stack is empty.
- R2: `full_o` is high exactly when all 32 entries are occupied.
- R3: A push while full discards the operand and leaves the stack unchanged. It sets `stk_ovf_o`, which stays high until a clear or a reset.
- R4: A pop (op code 1) on a non-empty stack removes the top entry at the accepting edge without raising `busy_o`.
- R5: An add (op code 2) replaces the two top entries with their sum modulo 256, so the stack loses one entry. `busy_o` is high for exactly 3 cycles.
- R6: `arith_ovf_o` reflects the most recent add, subtract or negate. For an add it is set when both operands share a sign and the result sign differs. For a subtract it is set when the operand signs differ and the result sign differs from the minuend. Negating 0x80 sets it.
- R7: A subtract (op code 3) replaces the two top entries with (entry below top) minus (top). `busy_o` is high for exactly 3 cycles.
- R8: A negate (op code 4) replaces the top entry with 0 minus top and leaves the depth unchanged. `busy_o` is high for exactly 2 cycles.
- R9: A swap (op code 5) exchanges the top entry and the entry below it. `busy_o` is high for exactly 4 cycles.
- R10: A clear (op code 6), like reset, empties the stack and clears `stk_ovf_o`, `arith_ovf_o` and `err_o`.
- R11: In each of these cases the stack is left unchanged and `err_o` is high for exactly one cycle: add, subtract or swap with fewer than two entries, and pop or negate on an empty stack.
- R12: A command presented while `busy_o` is high is dropped and has no effect.
- R13: Op code 7 is a no-operation. It changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | One-cycle command strobe |
| op_code_i | input | 3 | Operation code: 0 push, 1 pop, 2 add, 3 sub, 4 negate, 5 swap, 6 clear, 7 none |
| operand_i | input | 8 | Value to push |
| top_o | output | 8 | Current top entry, 0 when empty |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds 32 entries |
| stk_ovf_o | output | 1 | Sticky: a push hit a full stack |
| arith_ovf_o | output | 1 | Signed overflow of the last arithmetic command |
| err_o | output | 1 | One-cycle pulse for a rejected command |
| busy_o | output | 1 | Multi-cycle command in progress |

## Verification
A wrong stack pointer shows on `top_o` at the first negedge after the offending edge, because the top is read combinationally from the pointer. It shows again on later pops, which return the wrong entries or reach `empty_o` early or late. Wrong holding-register capture or wrong operand ordering appears on `top_o` when `busy_o` falls after an arithmetic command or swap, and the entry left underneath is checked with a further pop. A wrong sequencer length shows at once as a busy count that differs from 2, 3 or 4 cycles.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_NEG   = 3'd4,
    OP_SWAP  = 3'd5,
    OP_CLEAR = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TAKE_B = 3'd1,
    ST_TAKE_A = 3'd2,
    ST_WRITE  = 3'd3,
    ST_WRITE2 = 3'd4
  } seq_e;

endpackage

// File: rtl/rpn_lifo.sv
module rpn_lifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  top_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count_q;
  logic [AW-1:0] top_idx;
  logic [AW-1:0] wr_idx;

  assign top_idx = AW'(count_q - CW'(1));
  assign wr_idx  = count_q[AW-1:0];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;
  assign top_o   = empty_o ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (push_i && !full_o && !clr_i) mem[wr_idx] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count_q <= '0;
    else if (clr_i)                count_q <= '0;
    else if (push_i && !full_o)    count_q <= count_q + CW'(1);
    else if (pop_i && !empty_o)    count_q <= count_q - CW'(1);
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R3
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R11
  AST_PUSH_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |=> (top_o == $past(wdata_i))); // R1

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);

  // one adder: invert b and inject carry for subtraction
  function automatic logic [W-1:0] f_sum(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic         sub);
    logic [W-1:0] bx;
    bx = b ^ {W{sub}};
    return a + bx + W'(sub);
  endfunction

  // sign rule: effective second-operand sign equals a's, result sign differs
  function automatic logic f_ovf(input logic [W-1:0] a,
                                 input logic [W-1:0] b,
                                 input logic [W-1:0] s,
                                 input logic         sub);
    logic bs;
    bs = b[W-1] ^ sub;
    return (a[W-1] == bs) && (s[W-1] != a[W-1]);
  endfunction

  assign res_o = f_sum(a_i, b_i, sub_i);
  assign ovf_o = f_ovf(a_i, b_i, res_o, sub_i);

endmodule

// File: rtl/rpn_stack_calc.sv
module rpn_stack_calc #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid_i,
  input  logic [2:0]   op_code_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         stk_ovf_o,
  output logic         arith_ovf_o,
  output logic         err_o,
  output logic         busy_o
);
  import rpn_pkg::*;

  seq_e          state_q, state_d;
  op_e           op_q, op_in;
  logic [W-1:0]  tmp_a_q, tmp_b_q;
  logic          err_q, sovf_q, aovf_q;

  logic          s_push, s_pop, s_clr;
  logic [W-1:0]  s_wdata, s_top;
  logic [CW-1:0] s_count;
  logic          s_empty, s_full;

  logic [W-1:0]  alu_a, alu_res;
  logic          alu_sub, alu_ovf;

  // named internal events
  logic accept, is_bin, is_seq, reject, push_now, pop_now, ovf_hit, clr_now;
  logic start_seq, take_b, take_a, wb, wb2;

  assign op_in     = op_e'(op_code_i);
  assign accept    = op_valid_i && (state_q == ST_IDLE);
  assign is_bin    = (op_in == OP_ADD) || (op_in == OP_SUB) || (op_in == OP_SWAP);
  assign is_seq    = is_bin || (op_in == OP_NEG);
  assign reject    = accept && ((is_bin && (s_count < CW'(2))) ||
                     (((op_in == OP_POP) || (op_in == OP_NEG)) && s_empty));
  assign push_now  = accept && (op_in == OP_PUSH) && !s_full;
  assign ovf_hit   = accept && (op_in == OP_PUSH) && s_full;
  assign pop_now   = accept && (op_in == OP_POP) && !s_empty;
  assign clr_now   = accept && (op_in == OP_CLEAR);
  assign start_seq = accept && is_seq && !reject;
  assign take_b    = (state_q == ST_TAKE_B);
  assign take_a    = (state_q == ST_TAKE_A);
  assign wb        = (state_q == ST_WRITE);
  assign wb2       = (state_q == ST_WRITE2);

  assign alu_a   = (op_q == OP_NEG) ? '0 : tmp_a_q;
  assign alu_sub = (op_q != OP_ADD);

  rpn_alu #(.W(W)) u_alu (
    .a_i   (alu_a),
    .b_i   (tmp_b_q),
    .sub_i (alu_sub),
    .res_o (alu_res),
    .ovf_o (alu_ovf)
  );

  assign s_clr   = clr_now;
  assign s_pop   = pop_now || take_b || take_a;
  assign s_push  = push_now || wb || wb2;
  assign s_wdata = push_now ? operand_i :
                   wb       ? ((op_q == OP_SWAP) ? tmp_b_q : alu_res) :
                              tmp_a_q;

  rpn_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (s_push),
    .pop_i   (s_pop),
    .clr_i   (s_clr),
    .wdata_i (s_wdata),
    .top_o   (s_top),
    .count_o (s_count),
    .empty_o (s_empty),
    .full_o  (s_full)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_seq) state_d = ST_TAKE_B;
      ST_TAKE_B: state_d = (op_q == OP_NEG) ? ST_WRITE : ST_TAKE_A;
      ST_TAKE_A: state_d = ST_WRITE;
      ST_WRITE:  state_d = (op_q == OP_SWAP) ? ST_WRITE2 : ST_IDLE;
      ST_WRITE2: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      tmp_a_q <= '0;
      tmp_b_q <= '0;
      err_q   <= 1'b0;
      sovf_q  <= 1'b0;
      aovf_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
      if (start_seq) op_q    <= op_in;
      if (take_b)    tmp_b_q <= s_top;
      if (take_a)    tmp_a_q <= s_top;
      if (clr_now)      sovf_q <= 1'b0;
      else if (ovf_hit) sovf_q <= 1'b1;
      if (clr_now)                      aovf_q <= 1'b0;
      else if (wb && op_q != OP_SWAP)   aovf_q <= alu_ovf;
    end
  end

  assign top_o       = s_top;
  assign empty_o     = s_empty;
  assign full_o      = s_full;
  assign stk_ovf_o   = sovf_q;
  assign arith_ovf_o = aovf_q;
  assign err_o       = err_q;
  assign busy_o      = (state_q != ST_IDLE);

  AST_ERR_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (s_count == $past(s_count))); // R11
  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && op_valid_i) |=> (!err_o && $stable(stk_ovf_o))); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ovf_o && !clr_now) |=> stk_ovf_o); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (empty_o && !stk_ovf_o && !arith_ovf_o)); // R10
  AST_ADD_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb && op_q == OP_ADD && tmp_a_q[W-1] == tmp_b_q[W-1] &&
     alu_res[W-1] != tmp_a_q[W-1]) |=> arith_ovf_o); // R6
  AST_NEG_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wb && op_q == OP_NEG) |=> (s_count == $past(s_count) + CW'(1))); // R8

endmodule

// File: tb/rpn_stack_calc_test.sv
module rpn_stack_calc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [2:0] op_code_i = 3'd7;
  logic [7:0] operand_i = 8'd0;
  logic [7:0] top_o;
  logic       empty_o, full_o, stk_ovf_o, arith_ovf_o, err_o, busy_o;

  int checks = 0;
  int errors = 0;
  int busy_cycles;
  int last_err;

  always #10 clk = ~clk;

  rpn_stack_calc uut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .operand_i(operand_i), .top_o(top_o), .empty_o(empty_o), .full_o(full_o),
    .stk_ovf_o(stk_ovf_o), .arith_ovf_o(arith_ovf_o), .err_o(err_o), .busy_o(busy_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int s8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int ovf_of(int sum);
    return (sum > 127 || sum < -128) ? 1 : 0;
  endfunction

  // issue one command, then wait for busy to drop while counting it
  task automatic do_cmd(int code, int val);
    @(negedge clk);
    op_valid_i = 1'b1;
    op_code_i  = 3'(code);
    operand_i  = 8'(val);
    @(negedge clk);
    op_valid_i = 1'b0;
    op_code_i  = 3'd7;
    last_err    = int'(err_o);
    busy_cycles = 0;
    while (busy_o) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 empty after reset", int'(empty_o), 1);
    chk("R1 top zero when empty", int'(top_o), 0);
    chk("R2 not full after reset", int'(full_o), 0);
    chk("R10 flags clear after reset", int'({stk_ovf_o, arith_ovf_o, err_o, busy_o}), 0);
  endtask

  task automatic t_push_pop;
    do_cmd(0, 5);
    chk("R1 push top", int'(top_o), 5);
    chk("R1 push no busy", busy_cycles, 0);
    chk("R1 not empty", int'(empty_o), 0);
    do_cmd(0, 8'hA0);
    chk("R1 second push top", int'(top_o), 8'hA0);
    do_cmd(1, 0);
    chk("R4 pop reveals below", int'(top_o), 5);
    chk("R4 pop no busy", busy_cycles, 0);
    do_cmd(1, 0);
    chk("R4 pop to empty", int'(empty_o), 1);
  endtask

  task automatic t_add;
    do_cmd(0, 100); do_cmd(0, 27); do_cmd(2, 0);
    chk("R5 add result", int'(top_o), 127);
    chk("R5 add busy", busy_cycles, 3);
    chk("R6 add no ovf", int'(arith_ovf_o), ovf_of(100 + 27));
    do_cmd(1, 0);
    chk("R5 add removed one entry", int'(empty_o), 1);
    do_cmd(0, 100); do_cmd(0, 28); do_cmd(2, 0);
    chk("R5 add wrap", int'(top_o), (100 + 28) & 255);
    chk("R6 add ovf", int'(arith_ovf_o), ovf_of(100 + 28));
    do_cmd(0, 8'hF0); do_cmd(0, 8'hF0); do_cmd(2, 0);
    chk("R6 add of negatives", int'(arith_ovf_o), ovf_of(s8(8'hF0) + s8(8'hF0)));
    chk("R5 add negatives", int'(top_o), (8'hF0 + 8'hF0) & 255);
    do_cmd(6, 0);
  endtask

  task automatic t_sub;
    do_cmd(0, 10); do_cmd(0, 3); do_cmd(3, 0);
    chk("R7 sub order", int'(top_o), 7);
    chk("R7 sub busy", busy_cycles, 3);
    chk("R6 sub no ovf", int'(arith_ovf_o), 0);
    do_cmd(0, 3); do_cmd(0, 10); do_cmd(3, 0);
    chk("R7 sub negative", int'(top_o), (3 - 10) & 255);
    do_cmd(0, 8'h80); do_cmd(0, 1); do_cmd(3, 0);
    chk("R7 sub wrap", int'(top_o), 8'h7F);
    chk("R6 sub ovf", int'(arith_ovf_o), ovf_of(s8(8'h80) - 1));
    do_cmd(6, 0);
  endtask

  task automatic t_neg;
    do_cmd(0, 1); do_cmd(0, 5); do_cmd(4, 0);
    chk("R8 neg value", int'(top_o), 256 - 5);
    chk("R8 neg busy", busy_cycles, 2);
    chk("R6 neg no ovf", int'(arith_ovf_o), 0);
    do_cmd(1, 0);
    chk("R8 neg keeps depth", int'(top_o), 1);
    do_cmd(0, 8'h80); do_cmd(4, 0);
    chk("R8 neg of min", int'(top_o), 8'h80);
    chk("R6 neg ovf", int'(arith_ovf_o), ovf_of(-s8(8'h80)));
    do_cmd(6, 0);
  endtask

  task automatic t_swap;
    do_cmd(0, 11); do_cmd(0, 22); do_cmd(5, 0);
    chk("R9 swap top", int'(top_o), 11);
    chk("R9 swap busy", busy_cycles, 4);
    do_cmd(1, 0);
    chk("R9 swap below", int'(top_o), 22);
    do_cmd(6, 0);
  endtask

  task automatic t_errors;
    do_cmd(1, 0);
    chk("R11 pop empty err", last_err, 1);
    @(negedge clk);
    chk("R11 err one cycle", int'(err_o), 0);
    do_cmd(4, 0);
    chk("R11 neg empty err", last_err, 1);
    chk("R11 neg empty stays empty", int'(empty_o), 1);
    do_cmd(0, 9);
    do_cmd(2, 0);
    chk("R11 add one entry err", last_err, 1);
    chk("R11 add no busy", busy_cycles, 0);
    do_cmd(3, 0);
    chk("R11 sub one entry err", last_err, 1);
    do_cmd(5, 0);
    chk("R11 swap one entry err", last_err, 1);
    chk("R11 top untouched", int'(top_o), 9);
    do_cmd(1, 0);
    chk("R11 single entry kept", int'(empty_o), 1);
    chk("R11 pop ok no err", last_err, 0);
  endtask

  task automatic t_full;
    for (int i = 1; i <= 31; i++) do_cmd(0, i);
    chk("R2 not full at 31", int'(full_o), 0);
    do_cmd(0, 32);
    chk("R2 full at 32", int'(full_o), 1);
    do_cmd(0, 8'h55);
    chk("R3 ovf set", int'(stk_ovf_o), 1);
    chk("R3 data discarded", int'(top_o), 32);
    do_cmd(1, 0);
    chk("R3 stack intact", int'(top_o), 31);
    chk("R2 full drops", int'(full_o), 0);
    chk("R3 ovf sticky", int'(stk_ovf_o), 1);
    do_cmd(0, 8'h7F); do_cmd(0, 1); do_cmd(2, 0);
    chk("R6 ovf before clear", int'(arith_ovf_o), 1);
    do_cmd(6, 0);
    chk("R10 clear empties", int'(empty_o), 1);
    chk("R10 clear flags", int'({stk_ovf_o, arith_ovf_o}), 0);
    chk("R10 clear top", int'(top_o), 0);
  endtask

  task automatic t_busy_drop;
    do_cmd(0, 2); do_cmd(0, 3);
    @(negedge clk);
    op_valid_i = 1'b1; op_code_i = 3'd2;
    @(negedge clk);
    op_code_i = 3'd0; operand_i = 8'h77;
    @(negedge clk);
    op_code_i = 3'd6;
    @(negedge clk);
    op_valid_i = 1'b0; op_code_i = 3'd7;
    while (busy_o) @(negedge clk);
    chk("R12 push dropped", int'(top_o), 5);
    do_cmd(1, 0);
    chk("R12 clear dropped, depth one", int'(empty_o), 1);
  endtask

  task automatic t_nop;
    do_cmd(0, 4);
    do_cmd(7, 0);
    chk("R13 nop top", int'(top_o), 4);
    chk("R13 nop no err", last_err, 0);
    chk("R13 nop no busy", busy_cycles, 0);
    do_cmd(6, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_add();
    t_sub();
    t_neg();
    t_swap();
    t_errors();
    t_full();
    t_busy_drop();
    t_nop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule